// File: doc/BRIEF.md
# SDRAM Command Sequencer with Programmable Timing

This block turns single read or write requests from a host port into SDRAM command sequences. It drives chip select, the three command strobes (row strobe, column strobe, write enable), the bank select and the multiplexed address bus. It keeps a record of the open row in every bank. A request to the open row goes straight to the column command. A request to a closed bank first activates the row. A request to a different row of an open bank first precharges that bank, then activates the new row.

Four configuration inputs set the timing: CAS latency, row-to-column delay, precharge time, and a leadoff option for host reads. The leadoff option delays the first chip-select assertion of a read by one clock. Any combination of the four is legal. The block captures the configuration when it accepts a request, and keeps using that copy until the sequence ends. For a read, it raises a data-valid strobe when the CAS latency has elapsed. For every request it returns a done pulse to the host port.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is active and after it is released, chip select and all three command strobes are high. `reqReady` is high, `rdValid` and `reqDone` are low, and every bank is recorded as closed.
- R2: `reqAddr` is split as {bank, row, column}, with the column in the low bits. `sdBa` carries the bank while command lines are driven. An activate places the row on `sdAddr`. A read or write places the zero-extended column on `sdAddr`. A precharge places zero, which selects a single bank.
- R3: Clock 1 is the cycle in which `reqValid` and `reqReady` are both high. The first command goes out with chip select low in clock 3 for a write, and for a read with `cfgLeadSlow`=0. For a read with `cfgLeadSlow`=1 it goes out in clock 4. In the clock just before that command, the command lines and the address already carry it while chip select stays high.
- R4: A request to a closed bank issues an activate as its first command.
- R5: A request to the open row of its bank issues the column command (read or write) as its first command.
- R6: A request to a different row of an open bank issues a precharge first, then an activate of the new row, then the column command. Afterwards the new row is recorded as open.
- R7: An activate follows a precharge after exactly 2 clocks (`cfgRp3`=0) or 3 clocks (`cfgRp3`=1). Two commands are never issued in adjacent clocks.
- R8: The column command follows an activate after exactly 2 clocks (`cfgRcd3`=0) or 3 clocks (`cfgRcd3`=1).
- R9: `rdValid` and `reqDone` pulse together for one clock, exactly CAS-latency clocks after the read command. The latency is 2 for `cfgCl3`=0 and 3 for `cfgCl3`=1. For a write, `reqDone` pulses in the clock of the write command.
- R10: In every clock that carries neither a command nor the staging of R3, chip select and the command strobes are all high (NOP).
- R11: Configuration inputs are sampled only in the clock that accepts a request. Changing them during a sequence has no effect on that sequence.
- R12: `reqReady` is high only while idle. A `reqValid` that arrives while `reqReady` is low is ignored. `reqReady` returns in the clock after `reqDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCl3 | input | 1 | CAS latency select: 0 gives 2 clocks, 1 gives 3 |
| cfgRcd3 | input | 1 | Row-to-column delay select: 0 gives 2 clocks, 1 gives 3 |
| cfgRp3 | input | 1 | Precharge time select: 0 gives 2 clocks, 1 gives 3 |
| cfgLeadSlow | input | 1 | Host read leadoff: 0 puts chip select in clock 3, 1 puts it in clock 4 |
| reqValid | input | 1 | Host request strobe |
| reqReady | output | 1 | Sequencer idle and able to accept a request |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | BANK_W+ROW_W+COL_W | Request address {bank, row, column} |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W | Bank select |
| sdAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rdValid | output | 1 | Read data valid strobe |
| reqDone | output | 1 | Request completion pulse |

## Verification
The embedded assertions check, on every clock, the local spacing rules. These are the precharge-to-activate and activate-to-column gaps for the captured settings, the minimum gap between commands, that `rdValid` only follows a read command by two or three clocks, and that the host handshake returns to idle after each done pulse. The bench scoreboard covers what needs knowledge of the page state and of the whole request. That includes whether a request should hit, open or conflict, the exact clock of the first chip select under each leadoff setting, the address and bank on every command, that configuration changes and stray requests during a sequence are ignored, and that no command or staging appears outside its expected clock.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } sdCmd_e;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_RP,
    LD_RCD,
    LD_CL
  } cntLoad_e;

  // control -> datapath
  typedef struct packed {
    logic     latchReq;
    cntLoad_e cntLoad;
    logic     cntDec;
    logic     setOpen;
    logic     clrOpen;
    sdCmd_e   cmd;
    logic     lineEn;
    logic     csEn;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pageHit;
    logic pageConflict;
    logic isWrite;
    logic cntZero;
    logic cntOne;
  } seqStatus_t;

  localparam int unsigned TIMER_W = 2;

endpackage

// File: rtl/sdseq_dpath.sv
module sdseq_dpath
  import sdseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int MA_W   = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgCl3,
  input  logic                          cfgRcd3,
  input  logic                          cfgRp3,
  input  logic                          cfgLeadSlow,
  input  logic                          reqWrite,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  seqStrobe_t                    strobe,
  output seqStatus_t                    status,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [MA_W-1:0]               sdAddr
);

  localparam int NBANK = 1 << BANK_W;

  // captured request and configuration
  logic [BANK_W-1:0]  bankQ;
  logic [ROW_W-1:0]   rowQ;
  logic [COL_W-1:0]   colQ;
  logic               writeQ;
  logic               cl3Q, rcd3Q, rp3Q;
  logic [TIMER_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= '0;
      rowQ   <= '0;
      colQ   <= '0;
      writeQ <= 1'b0;
      cl3Q   <= 1'b0;
      rcd3Q  <= 1'b0;
      rp3Q   <= 1'b0;
    end else if (strobe.latchReq) begin
      colQ   <= reqAddr[COL_W-1:0];
      rowQ   <= reqAddr[COL_W +: ROW_W];
      bankQ  <= reqAddr[COL_W+ROW_W +: BANK_W];
      writeQ <= reqWrite;
      cl3Q   <= cfgCl3;
      rcd3Q  <= cfgRcd3;
      rp3Q   <= cfgRp3;
    end
  end

  // shared wait timer: leadoff, precharge, row-to-column and latency windows
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.latchReq) begin
      timer <= (!reqWrite && cfgLeadSlow) ? TIMER_W'(1) : TIMER_W'(0);
    end else begin
      unique case (strobe.cntLoad)
        LD_RP:   timer <= rp3Q  ? TIMER_W'(2) : TIMER_W'(1);
        LD_RCD:  timer <= rcd3Q ? TIMER_W'(2) : TIMER_W'(1);
        LD_CL:   timer <= cl3Q  ? TIMER_W'(2) : TIMER_W'(1);
        default: if (strobe.cntDec) timer <= timer - 1'b1;
      endcase
    end
  end

  // open-row record, one entry per bank
  logic [NBANK-1:0] bankOpen;
  logic [NBANK-1:0] bankMatch;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             openVld;
    logic [ROW_W-1:0] openRow;
    logic             selThis;

    assign selThis = (bankQ == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openVld <= 1'b0;
        openRow <= '0;
      end else if (selThis && strobe.setOpen) begin
        openVld <= 1'b1;
        openRow <= rowQ;
      end else if (selThis && strobe.clrOpen) begin
        openVld <= 1'b0;
      end
    end

    assign bankOpen[b]  = openVld;
    assign bankMatch[b] = (openRow == rowQ);
  end

  always_comb begin
    status.pageHit      = bankOpen[bankQ] && bankMatch[bankQ];
    status.pageConflict = bankOpen[bankQ] && !bankMatch[bankQ];
    status.isWrite      = writeQ;
    status.cntZero      = (timer == '0);
    status.cntOne       = (timer == TIMER_W'(1));
  end

  // command line encoding and address multiplexing
  logic [2:0]      rcw;
  logic [MA_W-1:0] maMux;

  always_comb begin
    rcw   = 3'b111;
    maMux = '0;
    if (strobe.lineEn) begin
      unique case (strobe.cmd)
        CMD_ACT: begin rcw = 3'b011; maMux[ROW_W-1:0] = rowQ; end
        CMD_RD:  begin rcw = 3'b101; maMux[COL_W-1:0] = colQ; end
        CMD_WR:  begin rcw = 3'b100; maMux[COL_W-1:0] = colQ; end
        CMD_PRE: begin rcw = 3'b010; end
        default: begin rcw = 3'b111; end
      endcase
    end
  end

  assign sdCsN  = !strobe.csEn;
  assign sdRasN = rcw[2];
  assign sdCasN = rcw[1];
  assign sdWeN  = rcw[0];
  assign sdBa   = strobe.lineEn ? bankQ : '0;
  assign sdAddr = maMux;

  // bus-level timing checks
  logic isPre, isAct, isCol;
  assign isPre = !sdCsN && {sdRasN, sdCasN, sdWeN} == 3'b010;
  assign isAct = !sdCsN && {sdRasN, sdCasN, sdWeN} == 3'b011;
  assign isCol = !sdCsN && sdRasN && !sdCasN;

  AST_PRE_ACT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    isPre && !rp3Q |-> ##2 isAct);                                      // R7
  AST_PRE_ACT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    isPre && rp3Q |-> ##3 isAct);                                       // R7
  AST_ACT_COL_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    isAct && !rcd3Q |-> ##2 isCol);                                     // R8
  AST_ACT_COL_LONG: assert property (@(posedge clk) disable iff (!rstN)
    isAct && rcd3Q |-> ##3 isCol);                                      // R8
  AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    !sdCsN |=> sdCsN);                                                  // R7

endmodule

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       reqReady,
  output logic       rdValid,
  output logic       reqDone
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_ISSUE,
    S_WAIT,
    S_RDWAIT,
    S_RDDONE
  } seqState_e;

  seqState_e stateQ, stateD;
  sdCmd_e    curCmdQ, curCmdD;
  sdCmd_e    firstCmd, colCmd;

  assign colCmd   = status.isWrite ? CMD_WR : CMD_RD;
  assign firstCmd = status.pageHit      ? colCmd  :
                    status.pageConflict ? CMD_PRE : CMD_ACT;

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    curCmdD  = curCmdQ;
    reqReady = 1'b0;
    rdValid  = 1'b0;
    reqDone  = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateD          = S_LEAD;
        end
      end
      S_LEAD: begin
        if (status.cntZero) begin
          strobe.lineEn = 1'b1;        // stage lines one clock ahead of select
          strobe.cmd    = firstCmd;
          curCmdD       = firstCmd;
          stateD        = S_ISSUE;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      S_ISSUE: begin
        strobe.lineEn = 1'b1;
        strobe.csEn   = 1'b1;
        strobe.cmd    = curCmdQ;
        unique case (curCmdQ)
          CMD_PRE: begin
            strobe.clrOpen = 1'b1;
            strobe.cntLoad = LD_RP;
            curCmdD        = CMD_ACT;
            stateD         = S_WAIT;
          end
          CMD_ACT: begin
            strobe.setOpen = 1'b1;
            strobe.cntLoad = LD_RCD;
            curCmdD        = colCmd;
            stateD         = S_WAIT;
          end
          CMD_RD: begin
            strobe.cntLoad = LD_CL;
            stateD         = S_RDWAIT;
          end
          default: begin
            reqDone = 1'b1;
            stateD  = S_IDLE;
          end
        endcase
      end
      S_WAIT: begin
        if (status.cntOne) stateD = S_ISSUE;
        else               strobe.cntDec = 1'b1;
      end
      S_RDWAIT: begin
        if (status.cntOne) stateD = S_RDDONE;
        else               strobe.cntDec = 1'b1;
      end
      S_RDDONE: begin
        rdValid = 1'b1;
        reqDone = 1'b1;
        stateD  = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      curCmdQ <= CMD_NOP;
    end else begin
      stateQ  <= stateD;
      curCmdQ <= curCmdD;
    end
  end

  logic readIssued;
  assign readIssued = (stateQ == S_ISSUE) && (curCmdQ == CMD_RD);

  AST_RDV_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(readIssued, 2) || $past(readIssued, 3)));        // R9
  AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> reqReady);                                              // R12
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && reqValid |=> !reqReady);                                // R12

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter  int BANK_W = 2,
  parameter  int ROW_W  = 12,
  parameter  int COL_W  = 9,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCl3,
  input  logic              cfgRcd3,
  input  logic              cfgRp3,
  input  logic              cfgLeadSlow,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [MA_W-1:0]   sdAddr,
  output logic              rdValid,
  output logic              reqDone
);

  seqStrobe_t strobe;
  seqStatus_t status;

  sdseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .status   (status),
    .strobe   (strobe),
    .reqReady (reqReady),
    .rdValid  (rdValid),
    .reqDone  (reqDone)
  );

  sdseq_dpath #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .MA_W   (MA_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .cfgCl3      (cfgCl3),
    .cfgRcd3     (cfgRcd3),
    .cfgRp3      (cfgRp3),
    .cfgLeadSlow (cfgLeadSlow),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .strobe      (strobe),
    .status      (status),
    .sdCsN       (sdCsN),
    .sdRasN      (sdRasN),
    .sdCasN      (sdCasN),
    .sdWeN       (sdWeN),
    .sdBa        (sdBa),
    .sdAddr      (sdAddr)
  );

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> sdCsN && sdRasN && sdCasN && sdWeN);                   // R10

endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;

  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 9;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int MA_W   = 12;
  localparam int NBANK  = 1 << BANK_W;

  localparam int K_STAGE = 0, K_CMD = 1, K_RDV = 2, K_DONE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCl3 = 1'b0, cfgRcd3 = 1'b0, cfgRp3 = 1'b0, cfgLeadSlow = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqReady, sdCsN, sdRasN, sdCasN, sdWeN, rdValid, reqDone;
  logic [BANK_W-1:0] sdBa;
  logic [MA_W-1:0]   sdAddr;

  always #4 clk = ~clk;   // 125 MHz

  sdram_cmd_seq dut (
    .clk(clk), .rstN(rstN), .cfgCl3(cfgCl3), .cfgRcd3(cfgRcd3), .cfgRp3(cfgRp3),
    .cfgLeadSlow(cfgLeadSlow), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr),
    .rdValid(rdValid), .reqDone(reqDone)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int       kind;
    int       at;
    logic [2:0] rcw;
    int       ba;
    int       addr;
    string    tag;
  } ev_t;

  ev_t expQ[$];

  // bench model of the open rows
  bit mOpen[NBANK];
  int mRow[NBANK];

  function automatic void pushEv(int kind, int at, logic [2:0] rcw, int ba, int addr, string tag);
    ev_t e;
    e.kind = kind; e.at = at; e.rcw = rcw; e.ba = ba; e.addr = addr; e.tag = tag;
    expQ.push_back(e);
  endfunction

  task automatic checkEv(int kind);
    ev_t e;
    logic [2:0] rcw;
    rcw = {sdRasN, sdCasN, sdWeN};
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected event kind %0d rcw %b at cycle %0d (expected none)", kind, rcw, cyc);
      return;
    end
    e = expQ.pop_front();
    if (e.kind != kind || e.at != cyc || (kind <= K_CMD && e.rcw != rcw)) begin
      errors++;
      $display("FAIL %s event kind %0d rcw %b cycle %0d (expected kind %0d rcw %b cycle %0d)",
               e.tag, kind, rcw, cyc, e.kind, e.rcw, e.at);
    end
    if (kind <= K_CMD) begin
      checks++;
      if (int'(sdBa) != e.ba || int'(sdAddr) != e.addr) begin
        errors++;
        $display("FAIL R2 bank %0d addr %0d at cycle %0d (expected bank %0d addr %0d)",
                 sdBa, sdAddr, cyc, e.ba, e.addr);
      end
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (sdCsN && {sdRasN, sdCasN, sdWeN} != 3'b111) checkEv(K_STAGE);
      if (!sdCsN) checkEv(K_CMD);
      if (rdValid) checkEv(K_RDV);
      if (reqDone) checkEv(K_DONE);
      while (expQ.size() > 0 && expQ[0].at <= cyc) begin
        ev_t e;
        e = expQ.pop_front();
        checks++;
        errors++;
        $display("FAIL %s missing event kind %0d at cycle %0d (expected rcw %b)", e.tag, e.kind, e.at, e.rcw);
      end
    end
  end

  // driver: issue one request, push its expected bus events
  task automatic doReq(bit wr, int bk, int row, int col, bit cl3, bit rcd3, bit rp3, bit slow);
    int acc, first, t, endT, cl, rcd, rp;
    logic [2:0] colBits, firstBits;
    int firstAddr;
    bit hit, conflict;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    cfgCl3 = cl3; cfgRcd3 = rcd3; cfgRp3 = rp3; cfgLeadSlow = slow;
    reqWrite = wr;
    reqAddr  = ADDR_W'((bk << (ROW_W + COL_W)) | (row << COL_W) | col);
    reqValid = 1'b1;
    @(posedge clk);
    #1;
    acc = cyc;
    reqValid = 1'b0;
    cl = cl3 ? 3 : 2; rcd = rcd3 ? 3 : 2; rp = rp3 ? 3 : 2;
    colBits  = wr ? 3'b100 : 3'b101;
    hit      = mOpen[bk] && mRow[bk] == row;
    conflict = mOpen[bk] && mRow[bk] != row;
    first    = acc + ((!wr && slow) ? 2 : 1);    // R3: clock 3 or clock 4
    if (hit)           begin firstBits = colBits; firstAddr = col; end
    else if (conflict) begin firstBits = 3'b010;  firstAddr = 0;   end
    else               begin firstBits = 3'b011;  firstAddr = row; end
    pushEv(K_STAGE, first - 1, firstBits, bk, firstAddr, "R3");
    t = first;
    if (conflict) begin
      pushEv(K_CMD, t, 3'b010, bk, 0, "R6");
      t += rp;
      pushEv(K_CMD, t, 3'b011, bk, row, "R7");
      t += rcd;
      pushEv(K_CMD, t, colBits, bk, col, "R8");
    end else if (!hit) begin
      pushEv(K_CMD, t, 3'b011, bk, row, "R4");
      t += rcd;
      pushEv(K_CMD, t, colBits, bk, col, "R8");
    end else begin
      pushEv(K_CMD, t, colBits, bk, col, "R5");
    end
    mOpen[bk] = 1'b1;
    mRow[bk]  = row;
    if (wr) begin
      pushEv(K_DONE, t, 3'b000, 0, 0, "R9");
      endT = t;
    end else begin
      pushEv(K_RDV, t + cl, 3'b000, 0, 0, "R9");
      pushEv(K_DONE, t + cl, 3'b000, 0, 0, "R9");
      endT = t + cl;
    end
    // R11: flip configuration mid-sequence; R12: stray request while busy
    @(negedge clk);
    cfgCl3 = !cl3; cfgRcd3 = !rcd3; cfgRp3 = !rp3; cfgLeadSlow = !slow;
    reqWrite = !wr;
    reqAddr  = ~reqAddr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (cyc < endT + 1) @(negedge clk);
    checks++;
    if (reqReady !== 1'b1) begin
      errors++;
      $display("FAIL R12 reqReady %b one clock after done (expected 1)", reqReady);
    end
  endtask

  initial begin
    for (int b = 0; b < NBANK; b++) begin mOpen[b] = 1'b0; mRow[b] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} !== 4'b1111 || reqReady !== 1'b1 || rdValid !== 1'b0 || reqDone !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset cs/ras/cas/we %b ready %b rdv %b done %b (expected 1111 1 0 0)",
               {sdCsN, sdRasN, sdCasN, sdWeN}, reqReady, rdValid, reqDone);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} !== 4'b1111 || reqReady !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset cs/ras/cas/we %b ready %b (expected 1111 1)",
               {sdCsN, sdRasN, sdCasN, sdWeN}, reqReady);
    end
    doReq(0, 0, 5, 3, 0, 0, 0, 0);        // R4 closed bank, fast leadoff
    doReq(0, 0, 5, 7, 0, 0, 0, 1);        // R5 hit, R3 slow leadoff
    doReq(1, 0, 9, 1, 0, 1, 1, 0);        // R6 conflict write, long gaps
    doReq(0, 1, 2, 100, 1, 1, 0, 1);      // R9 latency 3, closed bank
    doReq(1, 1, 2, 511, 0, 0, 0, 1);      // R3 write ignores leadoff, hit
    for (int i = 0; i < 8; i++) begin     // every timing combination, R7 R8 R9
      doReq((i % 3) == 0, 2, i + 1, i * 37, i[0], i[1], i[2], i[0] ^ i[1]);
    end
    doReq(0, 3, 4095, 0, 1, 0, 1, 0);     // R2 extreme row and column
    doReq(0, 3, 4095, 511, 0, 1, 0, 0);   // R5 read hit
    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10 %0d expected events never seen (expected 0)", expQ.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule